// File: doc/BRIEF.md
# Row-Column Organised Static RAM

This block is an 8192-by-8 static RAM with a chip-style control interface. It has a 13-bit address, an 8-bit data bus, and three active-high strobes: chip select, output enable and write enable. The three-state data bus is split into three ports: `wr_data` carries data in, `rd_data` carries data out, and `rd_drive` is the drive enable that a pad or an outer bus model would use.

Each data bit is kept in its own plane of 256 rows by 32 columns, and the eight planes sit side by side. The upper eight address bits feed a one-hot row decoder that is shared by all planes. The lower five address bits feed each plane's column multiplexer, so addresses in sequence stay on one row.

The write strobe is the AND of chip select and write enable. A byte is stored when that strobe ends. The strobe is sampled on the system clock, and its falling edge is detected there. The address and data seen in the last clock cycle of the strobe are then committed at the next clock edge.

Top module: `sram_rowcol_8k`

## Requirements
- R1: When the write strobe (`chip_sel` AND `wr_en`) goes from high to low between two rising clock edges, the byte on `wr_data` at the address `addr` is stored. Both values are taken as they stood at the last rising edge where the strobe was high. The byte is readable from the next clock cycle on.
- R2: A strobe ended by dropping `chip_sel` while `wr_en` stays high stores the byte exactly as a strobe ended by dropping `wr_en` does.
- R3: `rd_drive` is high exactly when `chip_sel` and `out_en` are high and `wr_en` is low. In particular it is never high while the write strobe is high.
- R4: While `rd_drive` is low, `rd_data` is all zeros. This models a floating bus.
- R5: While `rd_drive` is high, `rd_data` shows the byte stored at `addr` in the same cycle, with no clock edge in between.
- R6: The read row decoder asserts exactly one row select, chosen by `addr[12:5]`, while `chip_sel` is high, and no row select while `chip_sel` is low.
- R7: Toggling `wr_en` while `chip_sel` is low stores nothing.
- R8: Addresses that differ only in the column bits `addr[4:0]`, or only in the row bits `addr[12:5]`, hold independent bytes.
- R9: No byte is stored while `rst_n` is low, even if a write strobe ends during reset.
- R10: After a long sequence of random writes, every location reads back the last byte written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; used to detect the end of the write strobe |
| rst_n | input | 1 | Asynchronous active-low reset of the strobe tracking |
| addr | input | 13 | Byte address; bits 12:5 select the row, bits 4:0 select the column |
| wr_data | input | 8 | Data into the memory (bus input direction) |
| chip_sel | input | 1 | Active-high chip select |
| out_en | input | 1 | Active-high output enable |
| wr_en | input | 1 | Active-high write enable |
| rd_data | output | 8 | Data out of the memory; zero while not driving |
| rd_drive | output | 1 | High when the memory drives the bus |

## Verification
The checker enforces these properties on every cycle:
- The read row select is one-hot or empty, and it is empty whenever the chip is deselected.
- The bus is never driven during a write strobe or while write enable is high.
- The output is zero whenever it is not driven.
- Every commit follows a cycle in which the strobe was high and takes place with the strobe low.

Some behaviour cannot be shown from one cycle and is left to the bench scenarios:
- Whether the right byte lands in the right cell.
- That a strobe ended by chip select still stores its byte.
- That writes during reset, or with the chip deselected, leave the contents alone.
- That random write traffic matches a flat reference model.

// File: rtl/sram_rc_pkg.sv
package sram_rc_pkg;
    localparam int ADDR_W = 13;
    localparam int DATA_W = 8;
    localparam int COL_W  = 5;
    localparam int ROW_W  = ADDR_W - COL_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int COLS   = 1 << COL_W;

    typedef struct packed {
        logic              strobe;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_track_t;
endpackage

// File: rtl/sram_rc_row_dec.sv
module sram_rc_row_dec #(
    parameter int ROW_W = 8,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic             en,
    input  logic [ROW_W-1:0] row,
    output logic [ROWS-1:0]  sel
);
    // one comparator per word line; at most one can match
    for (genvar r = 0; r < ROWS; r++) begin : g_line
        assign sel[r] = en && (row == ROW_W'(r));
    end
endmodule

// File: rtl/sram_rc_col_mux.sv
module sram_rc_col_mux #(
    parameter int COL_W = 5,
    localparam int COLS = 1 << COL_W
) (
    input  logic [COLS-1:0]  word,
    input  logic [COL_W-1:0] col,
    output logic             bit_o
);
    assign bit_o = word[col];
endmodule

// File: rtl/sram_rc_bit_plane.sv
module sram_rc_bit_plane #(
    parameter int ROW_W = 8,
    parameter int COL_W = 5,
    localparam int ROWS = 1 << ROW_W,
    localparam int COLS = 1 << COL_W
) (
    input  logic             clk,
    input  logic [ROWS-1:0]  rd_row_sel,
    input  logic [COL_W-1:0] rd_col,
    input  logic [ROWS-1:0]  wr_row_sel,
    input  logic [COL_W-1:0] wr_col,
    input  logic             wr_bit,
    output logic             rd_bit
);
    logic [COLS-1:0] cells [ROWS];
    logic [COLS-1:0] row_word;

    // cell update: only the selected row, only the addressed column
    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wr_row_sel[r]) begin
                cells[r][wr_col] <= wr_bit;
            end
        end
    end

    // word-line gating: the selected row appears on the bit lines
    always_comb begin
        row_word = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (rd_row_sel[r]) begin
                row_word = row_word | cells[r];
            end
        end
    end

    sram_rc_col_mux #(.COL_W(COL_W)) u_col_mux (
        .word  (row_word),
        .col   (rd_col),
        .bit_o (rd_bit)
    );
endmodule

// File: rtl/sram_rowcol_8k.sv
module sram_rowcol_8k
    import sram_rc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              chip_sel,
    input  logic              out_en,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_drive
);
    wr_track_t trk_d, trk_q;
    logic      strobe;
    logic      wr_commit;

    logic [ROWS-1:0]   rd_row_sel;
    logic [ROWS-1:0]   wr_row_sel;
    logic [DATA_W-1:0] plane_bits;

    assign strobe = chip_sel & wr_en;

    // next state: follow the strobe, hold address/data from its last high cycle
    always_comb begin
        trk_d        = trk_q;
        trk_d.strobe = strobe;
        if (strobe) begin
            trk_d.addr = addr;
            trk_d.data = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    // falling edge of the strobe
    assign wr_commit = trk_q.strobe & ~strobe;

    sram_rc_row_dec #(.ROW_W(ROW_W)) u_rd_dec (
        .en  (chip_sel),
        .row (addr[ADDR_W-1:COL_W]),
        .sel (rd_row_sel)
    );

    sram_rc_row_dec #(.ROW_W(ROW_W)) u_wr_dec (
        .en  (wr_commit),
        .row (trk_q.addr[ADDR_W-1:COL_W]),
        .sel (wr_row_sel)
    );

    for (genvar b = 0; b < DATA_W; b++) begin : g_plane
        sram_rc_bit_plane #(.ROW_W(ROW_W), .COL_W(COL_W)) u_plane (
            .clk        (clk),
            .rd_row_sel (rd_row_sel),
            .rd_col     (addr[COL_W-1:0]),
            .wr_row_sel (wr_row_sel),
            .wr_col     (trk_q.addr[COL_W-1:0]),
            .wr_bit     (trk_q.data[b]),
            .rd_bit     (plane_bits[b])
        );
    end

    assign rd_drive = chip_sel & out_en & ~wr_en;
    assign rd_data  = rd_drive ? plane_bits : '0;
endmodule

// File: rtl/sram_rc_checker.sv
module sram_rc_checker
    import sram_rc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel,
    input logic              wr_en,
    input logic              rd_drive,
    input logic [DATA_W-1:0] rd_data,
    input logic [ROWS-1:0]   rd_row_sel,
    input logic              wr_commit
);
    assert_row_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rd_row_sel));

    assert_row_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !chip_sel |-> (rd_row_sel == '0));

    assert_no_drive_in_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_drive);

    assert_float_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_drive |-> (rd_data == '0));

    assert_commit_after_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> ($past(chip_sel && wr_en) && !(chip_sel && wr_en)));
endmodule

bind sram_rowcol_8k sram_rc_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_sel   (chip_sel),
    .wr_en      (wr_en),
    .rd_drive   (rd_drive),
    .rd_data    (rd_data),
    .rd_row_sel (rd_row_sel),
    .wr_commit  (wr_commit)
);

// File: tb/sram_rowcol_8k_tb.sv
module sram_rowcol_8k_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] addr = '0;
    logic [7:0]  wr_data = '0;
    logic        chip_sel = 1'b0;
    logic        out_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  rd_data;
    logic        rd_drive;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] ref_mem [512];

    always #10 clk = ~clk;

    sram_rowcol_8k u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (addr),
        .wr_data  (wr_data),
        .chip_sel (chip_sel),
        .out_en   (out_en),
        .wr_en    (wr_en),
        .rd_data  (rd_data),
        .rd_drive (rd_drive)
    );

    // {addr, data}: same-row columns, row neighbours and address extremes (R8)
    localparam logic [20:0] VEC [16] = '{
        {13'h0000, 8'h11}, {13'h0001, 8'h22}, {13'h001F, 8'h33}, {13'h0020, 8'h44},
        {13'h0021, 8'h55}, {13'h1FFF, 8'hA5}, {13'h1FE0, 8'h5A}, {13'h0FFF, 8'hC3},
        {13'h1000, 8'h3C}, {13'h0AAA, 8'hFF}, {13'h1555, 8'h00}, {13'h003F, 8'h81},
        {13'h07E1, 8'h7E}, {13'h0410, 8'h96}, {13'h0430, 8'h69}, {13'h1E0F, 8'hE7}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic write_byte(input logic [12:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; chip_sel = 1'b1; wr_en = 1'b1; out_en = 1'b0;
        @(negedge clk);
        chip_sel = 1'b0; wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_check(input string req, input logic [12:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a; chip_sel = 1'b1; out_en = 1'b1; wr_en = 1'b0;
        #2;
        check(req, 32'(rd_data), 32'(exp));
        chip_sel = 1'b0; out_en = 1'b0;
    endtask

    function automatic logic [12:0] win_addr(input int idx);
        logic [8:0] i = 9'(idx);
        return {i[8:5], 4'b0, i[4:0]};
    endfunction

    // bus must never be driven while a write strobe is up (R3)
    always @(posedge clk) begin
        if (rst_n && chip_sel && wr_en && rd_drive) begin
            n_bad++;
            $display("FAIL R3 drive during write actual=1 expected=0");
        end
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R4 reset rd_drive", 32'(rd_drive), 0);
        check("R4 reset rd_data", 32'(rd_data), 0);
        rst_n = 1'b1;

        // table walk: write then read back (R1, R5, R8)
        foreach (VEC[i]) write_byte(VEC[i][20:8], VEC[i][7:0]);
        foreach (VEC[i]) read_check("R1/R5/R8 table", VEC[i][20:8], VEC[i][7:0]);

        // R3/R4 drive enable over all strobe combinations
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            addr = 13'h0000; chip_sel = c[2]; out_en = c[1]; wr_en = c[0];
            #2;
            check("R3 drive combo", 32'(rd_drive), 32'(c == 6));
            check("R4 data combo", 32'(rd_data), (c == 6) ? 32'h11 : 32'h0);
        end
        @(negedge clk);
        chip_sel = 1'b0; out_en = 1'b0; wr_en = 1'b0;

        // R6: deselected read returns nothing even with out_en high
        @(negedge clk);
        addr = 13'h0001; chip_sel = 1'b0; out_en = 1'b1;
        #2;
        check("R6 deselected", 32'(rd_data), 0);
        out_en = 1'b0;

        // R2: strobe ended by chip select
        @(negedge clk);
        addr = 13'h0123; wr_data = 8'hB7; chip_sel = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        chip_sel = 1'b0;
        @(negedge clk);
        wr_en = 1'b0;
        read_check("R2 end by chip_sel", 13'h0123, 8'hB7);

        // R1: address/data from last strobe cycle; a change mid-strobe wins
        @(negedge clk);
        addr = 13'h0200; wr_data = 8'h01; chip_sel = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        addr = 13'h0201; wr_data = 8'h02;
        @(negedge clk);
        chip_sel = 1'b0; wr_en = 1'b0;
        read_check("R1 last cycle addr", 13'h0201, 8'h02);

        // R7: wr_en pulses without chip select
        write_byte(13'h0300, 8'h4D);
        @(negedge clk);
        addr = 13'h0300; wr_data = 8'hEE; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
        read_check("R7 deselected write", 13'h0300, 8'h4D);

        // R9: strobe ending inside reset commits nothing
        write_byte(13'h0404, 8'h19);
        @(negedge clk);
        rst_n = 1'b0;
        addr = 13'h0404; wr_data = 8'hF0; chip_sel = 1'b1; wr_en = 1'b1;
        @(negedge clk);
        chip_sel = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        read_check("R9 write in reset", 13'h0404, 8'h19);

        // R10: random traffic against a flat reference over a 512-byte window
        for (int i = 0; i < 512; i++) begin
            ref_mem[i] = 8'(i * 7 + 3);
            write_byte(win_addr(i), ref_mem[i]);
        end
        for (int k = 0; k < 400; k++) begin
            int idx = int'($urandom % 512);
            logic [7:0] d = 8'($urandom);
            ref_mem[idx] = d;
            write_byte(win_addr(idx), d);
        end
        for (int i = 0; i < 512; i++) begin
            read_check("R10 random readback", win_addr(i), ref_mem[i]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule